// File: doc/BRIEF.md
# Keypad PIN Sequence Lock

This block watches a keypad digit bus and recognises a fixed unlock code that is entered one digit per clock. The default code is 4, 1, 6, 9. The bus is sampled on every rising clock edge, so a digit that is held for several cycles counts as that many entries. When the final code digit arrives while the three digits before it matched in order, a registered unlock output goes high for exactly one clock cycle.

Each position of the code has its own stage. A wrong digit sends the machine straight back to idle, and it does not try to reuse that digit as the start of a new attempt. The last stage returns to idle after one cycle whatever digit it sees, and only that digit decides whether the pulse fires.

Parameters set the code length and the code value. The code is packed as one decimal digit per nibble, with the first digit in the most significant nibble. Another parameter selects binary or one-hot encoding of the stage register. Elaboration checks reject an illegal code.

Top module: `keypad_pin_lock`

## Requirements
- R1: While `rst_n` is low, `unlock_o` is 0 and the machine is idle. Pulling `rst_n` low takes effect at once, without waiting for a clock edge, and it clears an unlock pulse that is in progress.
- R2: If the samples on four consecutive rising edges are 4, 1, 6, 9, starting from idle, `unlock_o` is 1 for the one cycle after the edge that sampled the 9. It is 0 again after the next edge.
- R3: `key_digit` is sampled on every rising edge, so a held digit counts as several entries. Holding 4 for three edges and then entering 1, 6, 9 unlocks. Holding 4 for four edges and then entering 1, 6, 9 does not unlock.
- R4: In a stage that is not the last, a digit that does not match that stage's code digit returns the machine to idle. The digit is not reused as a new first digit, so 4, 4, 1, 6, 9 does not unlock.
- R5: A sequence with a wrong digit in any one position never raises `unlock_o`. Examples are 4119, 5169, 4769 and 4168.
- R6: The last stage always returns to idle on the next edge. 4, 1, 6, 5, 1, 6, 9 does not unlock. 4, 1, 6, 9, 1, 6, 9 gives one pulse only.
- R7: Bus values 10 to 15 never match any code digit. In idle they leave the machine idle, so 12, 4, 1, 6, 9 unlocks. In any other stage they act as a mismatch.
- R8: A correct code inside a longer digit stream still unlocks. For example, 2, 5, 4, 1, 6, 9, 1, 8 gives one pulse, after the 9.
- R9: `CODE` holds `CODE_LEN` digits, one 4-bit nibble per digit, with the first digit in the most significant nibble. A 3-digit code 0x705 using one-hot stage encoding unlocks on 7, 0, 5 and follows the same rules as the default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the digit bus is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_digit | input | DIGIT_W | Digit currently on the keypad bus |
| unlock_o | output | 1 | One-cycle registered unlock pulse |

## Verification
A stage register that is wrong shows at the ports only through `unlock_o`. The error becomes visible at the latest on the edge that samples what should be the final digit: either a pulse is missing, or a pulse appears that should not. Stage faults therefore show within one code length of the faulty transition. The stimulus is built so that such faults become pulse errors: held digits, a first digit repeated in place of a later one, non-digit values in every stage, and attempts placed back to back. A constrained random stream, biased toward the digit each stage expects, reaches every stage often and is checked against a reference model on every cycle.

// File: rtl/pinlock_pkg.sv
package pinlock_pkg;

   // largest value that counts as a decimal digit, plus one
   localparam int DECIMAL_BASE = 10;

   typedef enum logic {
      STG_BINARY = 1'b0,
      STG_ONEHOT = 1'b1
   } stage_enc_e;

   function automatic int stage_bits(input int len);
      return (len < 2) ? 1 : $clog2(len);
   endfunction

endpackage

// File: rtl/pinlock_digit_match.sv
module pinlock_digit_match #(
   parameter int                          DIGIT_W  = 4,
   parameter int                          CODE_LEN = 4,
   parameter logic [CODE_LEN*DIGIT_W-1:0] CODE     = 16'h4169
) (
   input  logic [DIGIT_W-1:0]  digit_i,
   output logic [CODE_LEN-1:0] hit_o
);

   // one comparator per code position; position 0 is the first digit (MSB nibble)
   for (genvar g = 0; g < CODE_LEN; g++) begin : g_pos
      localparam int LSB = (CODE_LEN - 1 - g) * DIGIT_W;
      assign hit_o[g] = (digit_i == CODE[LSB +: DIGIT_W]);
   end

endmodule

// File: rtl/pinlock_seq_ctrl.sv
module pinlock_seq_ctrl
   import pinlock_pkg::*;
#(
   parameter int         CODE_LEN = 4,
   parameter stage_enc_e ENC      = STG_BINARY,
   localparam int        STG_W    = stage_bits(CODE_LEN)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [CODE_LEN-1:0] hit_i,
   output logic [STG_W-1:0]    stage_o,
   output logic                fire_o
);

   localparam int LAST = CODE_LEN - 1;

   if (ENC == STG_BINARY) begin : g_bin
      logic [STG_W-1:0] stg_q, stg_d;

      always_comb begin
         if (stg_q == STG_W'(LAST))
            stg_d = '0;
         else if (hit_i[stg_q])
            stg_d = stg_q + STG_W'(1);
         else
            stg_d = '0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg_q <= '0;
         else        stg_q <= stg_d;
      end

      assign fire_o  = (stg_q == STG_W'(LAST)) && hit_i[LAST];
      assign stage_o = stg_q;
   end else begin : g_oh
      logic [CODE_LEN-1:0] oh_q, oh_d;
      logic [LAST-1:0]     adv;

      assign adv = oh_q[LAST-1:0] & hit_i[LAST-1:0];

      always_comb begin
         oh_d    = '0;
         oh_d[0] = ~|adv;
         for (int i = 0; i < LAST; i++)
            oh_d[i+1] = adv[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) oh_q <= CODE_LEN'(1);
         else        oh_q <= oh_d;
      end

      always_comb begin
         stage_o = '0;
         for (int i = 0; i < CODE_LEN; i++)
            if (oh_q[i]) stage_o = STG_W'(i);
      end

      assign fire_o = oh_q[LAST] & hit_i[LAST];
   end

endmodule

// File: rtl/pinlock_pulse_reg.sv
module pinlock_pulse_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic fire_i,
   output logic pulse_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_o <= 1'b0;
      else        pulse_o <= fire_i;
   end

endmodule

// File: rtl/keypad_pin_lock.sv
module keypad_pin_lock
   import pinlock_pkg::*;
#(
   parameter int                          DIGIT_W      = 4,
   parameter int                          CODE_LEN     = 4,
   parameter logic [CODE_LEN*DIGIT_W-1:0] CODE         = 16'h4169,
   parameter stage_enc_e                  STAGE_ENC    = STG_BINARY
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DIGIT_W-1:0] key_digit,
   output logic               unlock_o
);

   localparam int STG_W = stage_bits(CODE_LEN);

   // elaboration-time parameter checks
   if (DIGIT_W < 4) begin : g_bad_w
      $error("keypad_pin_lock: DIGIT_W must hold a decimal digit");
   end
   if (CODE_LEN < 2) begin : g_bad_len
      $error("keypad_pin_lock: CODE_LEN must be at least 2");
   end
   for (genvar g = 0; g < CODE_LEN; g++) begin : g_chk_digit
      if (CODE[(CODE_LEN-1-g)*DIGIT_W +: DIGIT_W] >= DIGIT_W'(DECIMAL_BASE)) begin : g_bad
         $error("keypad_pin_lock: code digit is not decimal");
      end
   end

   logic [CODE_LEN-1:0] hit_w;
   logic [STG_W-1:0]    stage_w;
   logic                fire_w;

   pinlock_digit_match #(
      .DIGIT_W  (DIGIT_W),
      .CODE_LEN (CODE_LEN),
      .CODE     (CODE)
   ) match_i (
      .digit_i (key_digit),
      .hit_o   (hit_w)
   );

   pinlock_seq_ctrl #(
      .CODE_LEN (CODE_LEN),
      .ENC      (STAGE_ENC)
   ) ctrl_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit_i   (hit_w),
      .stage_o (stage_w),
      .fire_o  (fire_w)
   );

   pinlock_pulse_reg pulse_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire_i  (fire_w),
      .pulse_o (unlock_o)
   );

endmodule

// File: rtl/pinlock_chk.sv
module pinlock_chk #(
   parameter int                          DIGIT_W  = 4,
   parameter int                          CODE_LEN = 4,
   parameter logic [CODE_LEN*DIGIT_W-1:0] CODE     = 16'h4169,
   parameter int                          STG_W    = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic [DIGIT_W-1:0] key_digit,
   input logic               unlock_o,
   input logic [STG_W-1:0]   stage
);

   localparam int                 LAST   = CODE_LEN - 1;
   localparam logic [DIGIT_W-1:0] FINAL  = CODE[DIGIT_W-1:0];
   localparam logic [DIGIT_W-1:0] BEFORE = CODE[2*DIGIT_W-1:DIGIT_W];

   logic [DIGIT_W-1:0] want;
   always_comb begin
      want = '0;
      for (int i = 0; i < CODE_LEN; i++)
         if (stage == STG_W'(i)) want = CODE[(CODE_LEN-1-i)*DIGIT_W +: DIGIT_W];
   end

   // R2
   pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unlock_o |=> !unlock_o);

   // R2
   pulse_digits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unlock_o |-> ($past(key_digit) == FINAL && $past(key_digit, 2) == BEFORE));

   // R6
   last_stage_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stage == STG_W'(LAST)) |=> (stage == '0));

   // R6
   stage_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stage <= STG_W'(LAST));

   // R4
   mismatch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stage != STG_W'(LAST) && key_digit != want) |=> (stage == '0));

   // R7
   nondigit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (key_digit >= DIGIT_W'(10)) |=> (stage == '0 && !unlock_o));

endmodule

bind keypad_pin_lock pinlock_chk #(
   .DIGIT_W  (DIGIT_W),
   .CODE_LEN (CODE_LEN),
   .CODE     (CODE),
   .STG_W    (STG_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .key_digit (key_digit),
   .unlock_o  (unlock_o),
   .stage     (stage_w)
);

// File: tb/keypad_pin_lock_tb_top.sv
`timescale 1ns/1ps
module keypad_pin_lock_tb_top;
   import pinlock_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] key = 4'd0;
   logic       unlock_a, unlock_b;

   int n_vec  = 0;
   int n_fail = 0;
   int st_a   = 0;
   int st_b   = 0;

   always #2 clk = ~clk;   // 250 MHz

   keypad_pin_lock dut_i (
      .clk(clk), .rst_n(rst_n), .key_digit(key), .unlock_o(unlock_a));

   keypad_pin_lock #(.CODE_LEN(3), .CODE(12'h705), .STAGE_ENC(STG_ONEHOT)) alt_i (
      .clk(clk), .rst_n(rst_n), .key_digit(key), .unlock_o(unlock_b));

   function automatic logic [3:0] want_of(input int len, input logic [15:0] code, input int st);
      return code[(len-1-st)*4 +: 4];
   endfunction

   // reference: next stage and whether this sample completes the code
   function automatic int ref_next(input int len, input logic [15:0] code, input int st,
                                   input logic [3:0] d, output bit fire);
      logic [3:0] w;
      w = want_of(len, code, st);
      fire = 1'b0;
      if (st == len - 1) begin
         fire = (d == w);
         return 0;
      end
      return (d == w) ? st + 1 : 0;
   endfunction

   task automatic check(input logic got, input logic exp, input string tag);
      n_vec++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: unlock=%0b expected %0b at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic step(input logic [3:0] d, input string tag);
      bit fa, fb;
      @(negedge clk);
      key = d;
      @(posedge clk);
      if (rst_n) begin
         st_a = ref_next(4, 16'h4169, st_a, d, fa);
         st_b = ref_next(3, 16'h0705, st_b, d, fb);
      end else begin
         st_a = 0; st_b = 0; fa = 0; fb = 0;
      end
      #1;
      check(unlock_a, fa, tag);
      check(unlock_b, fb, "R9");
   endtask

   task automatic run_seq(input logic [63:0] hx, input int n, input string tag);
      for (int i = 0; i < n; i++) step(hx[(n-1-i)*4 +: 4], tag);
      step(4'd0, tag);
   endtask

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   endtask

   initial begin
      #(200000 * 4);
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      finish_run();
   end

   initial begin
      // R1: digits applied during reset produce nothing
      #1 check(unlock_a, 1'b0, "R1");
      step(4'd4, "R1"); step(4'd1, "R1"); step(4'd6, "R1"); step(4'd9, "R1");
      step(4'd0, "R1");
      @(negedge clk) rst_n = 1'b1;

      run_seq(64'h4169, 4, "R2");
      run_seq(64'h25416918, 8, "R8");
      run_seq(64'h44169, 5, "R4");
      run_seq(64'h4119, 4, "R5");
      run_seq(64'h5169, 4, "R5");
      run_seq(64'h4769, 4, "R5");
      run_seq(64'h4168, 4, "R5");
      run_seq(64'h4165169, 7, "R6");
      run_seq(64'h4169169, 7, "R6");
      run_seq(64'h41694169, 8, "R6");
      run_seq(64'h444169, 6, "R3");
      run_seq(64'h4444169, 7, "R3");
      run_seq(64'h416F, 4, "R7");
      run_seq(64'h4A169, 5, "R7");
      run_seq(64'hC4169, 5, "R7");
      run_seq(64'h41C9, 4, "R7");
      run_seq(64'h705, 3, "R9");
      run_seq(64'h77057405, 8, "R9");

      // R1: asynchronous reset clears a live pulse without a clock edge
      step(4'd4, "R1"); step(4'd1, "R1"); step(4'd6, "R1"); step(4'd9, "R2");
      rst_n = 1'b0;
      #0.5;
      check(unlock_a, 1'b0, "R1");
      st_a = 0; st_b = 0;
      step(4'd0, "R1");
      @(negedge clk) rst_n = 1'b1;

      // constrained random stream, biased toward the expected digit
      void'($urandom(32'd20240611));
      for (int i = 0; i < 4000; i++) begin
         int r;
         logic [3:0] d;
         r = $urandom % 5;
         if (r < 2)       d = want_of(4, 16'h4169, st_a);
         else if (r == 2) d = want_of(3, 16'h0705, st_b);
         else             d = 4'($urandom % 16);
         step(d, "R8");
      end
      finish_run();
   end

endmodule